// File: doc/BRIEF.md
# Device Interrupt Requester

This block is the interrupt side of a single I/O device. When the device reports that it has become ready, a pending-request flag is set. A software-controlled enable decides whether that pending request is shown on a request line that is shared with other devices. The line is active low and wired together with the other devices. This block never drives the line high. It either pulls the line low or leaves it floating.

When the processor raises its acknowledge input and this device has a visible request, the device takes the acknowledge as its own. It clears its pending flag and places a reply frame on a set of tri-state data outputs. The frame holds an 8-bit type code, from which the processor forms a vector address, and a 16-bit information word, which the processor stores for the handler. Because each device supplies its own information word, several devices can share one handler routine.

Software programs the enable, the type code and the information word through a small write-only register port. Software can also drop a pending request through the same port.

Top module: `dev_irq_if`

## Requirements
- R1: Register writes use `wr_addr` as follows. Address 0 is control: bit 0 is the enable, and writing 1 to bit 1 clears the pending request. Address 1 loads the type code from `wr_data[7:0]`. Address 2 loads the information word from `wr_data[15:0]`. A write to address 3 changes nothing.
- R2: A one-cycle `ready_evt` sets the pending request from the next clock edge onward. If a set and a clear arrive in the same cycle, the set wins.
- R3: `irq_drive_low` is 1 exactly when the request is pending and the enable is 1. Clearing the enable releases the line but keeps the pending request.
- R4: While the device answers an acknowledge, `data_out` carries the reply frame, built as follows:
  - bits [7:0] hold the type code;
  - bits [23:8] hold the information word;
  - the upper bits are 0.
  The frame captures these values at the moment of acceptance. It does not change while the answer lasts, even if the registers are rewritten.
- R5: `data_oe` is 1 only while answering an acknowledge. `data_out` is all zero whenever `data_oe` is 0.
- R6: Accepting an acknowledge clears the pending request. The line is released in the same cycle that `data_oe` rises.
- R7: A software clear drops the pending request, and the line is released after that write.
- R8: An acknowledge is accepted only on a rising `iack` while the request is visible on the line. An `iack` that is already high when the request appears is not answered, and neither is an `iack` that arrives while the request is disabled.
- R9: After reset the enable is 0, the pending request is 0, the code and information word are 0, and no output drives anything.
- R10: The answer ends one clock after `iack` is sampled low. `data_oe` then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_evt | input | 1 | One-cycle pulse when the device becomes ready |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| iack | input | 1 | Interrupt acknowledge from the processor |
| irq_drive_low | output | 1 | 1 = pull the shared request line low, 0 = release it |
| data_oe | output | 1 | Output enable of the tri-state data pads |
| data_out | output | 32 | Reply frame for the data pads |

## Verification
The bench builds the block with its default widths:
- an 8-bit code;
- a 16-bit information word;
- a 32-bit data path.

With these widths, the zero padding above bit 23 of the reply frame is exercised and checked. The bench covers acknowledges that arrive with no visible request, with `iack` already held high, and with the enable off. It also checks that a ready event and a clear landing in the same cycle leave the request set. It checks that registers rewritten during an answer leave the frame unchanged.

// File: rtl/dirq_pkg.sv
// Shared definitions for the device interrupt requester.
// Assumes a two-bit register select on the write port.
package dirq_pkg;
    localparam int unsigned REG_ADDR_W   = 2;
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_CODE  = 2'd1,
        REG_INFO  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dirq_regs.sv
// Write-only register file: enable bit, type code, information word,
// and a single-cycle software clear strobe for the pending request.
// Assumes WDATA_W is at least as wide as CODE_W, INFO_W and the control bits.
module dirq_regs
    import dirq_pkg::*;
#(
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned INFO_W  = 16,
    parameter int unsigned WDATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [WDATA_W-1:0]    wr_data,
    output logic                  enable,
    output logic                  sw_clear,
    output logic [CODE_W-1:0]     code,
    output logic [INFO_W-1:0]     info
);
    reg_sel_e sel;
    logic     wr_ctrl;

    assign sel     = reg_sel_e'(wr_addr);
    assign wr_ctrl = wr_en && (sel == REG_CTRL);

    // Clear strobe: a control write with the clear bit set.
    assign sw_clear = wr_ctrl && wr_data[CTRL_CLR_BIT];

    // Enable bit holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (wr_ctrl) begin
            enable <= wr_data[CTRL_EN_BIT];
        end
    end

    // Type code holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (wr_en && (sel == REG_CODE)) begin
            code <= wr_data[CODE_W-1:0];
        end
    end

    // Information word holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info <= '0;
        end else if (wr_en && (sel == REG_INFO)) begin
            info <= wr_data[INFO_W-1:0];
        end
    end
endmodule

// File: rtl/dirq_req.sv
// Pending-request flag and request line drive.
// The flag is set by the device-ready event and cleared by an accepted
// acknowledge or a software clear; the set wins over a same-cycle clear.
// The line output only ever requests a pull-low.
module dirq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_evt,
    input  logic enable,
    input  logic accept,
    input  logic sw_clear,
    output logic pending,
    output logic line_low
);
    logic req_q;

    // Pending flag: set has priority over both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (ready_evt) begin
            req_q <= 1'b1;
        end else if (accept || sw_clear) begin
            req_q <= 1'b0;
        end
    end

    // Request is visible only while enabled.
    assign pending  = req_q && enable;
    assign line_low = pending;

    assert_ready_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |=> req_q);

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !line_low);
endmodule

// File: rtl/dirq_ack.sv
// Acknowledge responder: detects a rising acknowledge while the request is
// visible, captures the reply frame, and drives it until the acknowledge
// drops. Assumes iack is synchronous to clk.
module dirq_ack #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned INFO_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack,
    input  logic              pending,
    input  logic [CODE_W-1:0] code,
    input  logic [INFO_W-1:0] info,
    output logic              accept,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    localparam int unsigned FRAME_W = CODE_W + INFO_W;
    localparam int unsigned PAD_W   = DATA_W - FRAME_W;

    logic              iack_q;
    logic              busy_q;
    logic [DATA_W-1:0] frame;
    logic [DATA_W-1:0] snap_q;

    // Frame layout: code low, info above, zero padding at the top.
    generate
        if (PAD_W > 0) begin : g_pad
            assign frame = {{PAD_W{1'b0}}, info, code};
        end else begin : g_nopad
            assign frame = {info, code};
        end
    endgenerate

    // Accept only a fresh rising acknowledge while idle and requesting.
    assign accept = iack && !iack_q && pending && !busy_q;

    // Previous acknowledge level; resets high so a held acknowledge is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iack_q <= 1'b1;
        end else begin
            iack_q <= iack;
        end
    end

    // Answering state: entered on accept, left when acknowledge is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
        end else if (!iack) begin
            busy_q <= 1'b0;
        end
    end

    // Frame capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (accept) begin
            snap_q <= frame;
        end
    end

    assign data_oe  = busy_q;
    assign data_out = busy_q ? snap_q : '0;

    assert_reply_needs_iack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(iack));

    assert_frame_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));
endmodule

// File: rtl/dev_irq_if.sv
// Device interrupt requester top: register port, pending request with
// line drive, and acknowledge reply on tri-state data pads
// (data_oe is the pad enable).
module dev_irq_if
    import dirq_pkg::*;
#(
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned INFO_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WDATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ready_evt,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [WDATA_W-1:0]    wr_data,
    input  logic                  iack,
    output logic                  irq_drive_low,
    output logic                  data_oe,
    output logic [DATA_W-1:0]     data_out
);
    logic              enable;
    logic              sw_clear;
    logic              pending;
    logic              accept;
    logic [CODE_W-1:0] code;
    logic [INFO_W-1:0] info;

    dirq_regs #(.CODE_W(CODE_W), .INFO_W(INFO_W), .WDATA_W(WDATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .enable(enable), .sw_clear(sw_clear),
        .code(code), .info(info)
    );

    dirq_req u_req (
        .clk(clk), .rst_n(rst_n), .ready_evt(ready_evt), .enable(enable),
        .accept(accept), .sw_clear(sw_clear), .pending(pending),
        .line_low(irq_drive_low)
    );

    dirq_ack #(.CODE_W(CODE_W), .INFO_W(INFO_W), .DATA_W(DATA_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .iack(iack), .pending(pending),
        .code(code), .info(info), .accept(accept),
        .data_oe(data_oe), .data_out(data_out)
    );

    assert_line_released_on_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_oe) && !$past(ready_evt)) |-> !irq_drive_low);
endmodule

// File: tb/dev_irq_if_test.sv
// Scoreboard bench: acknowledge driver queues expected frames, a monitor
// pops and compares them when the reply starts.
module dev_irq_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        iack = 1'b0;
    logic        irq_drive_low;
    logic        data_oe;
    logic [31:0] data_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] expq[$];
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    dev_irq_if uut (
        .clk(clk), .rst_n(rst_n), .ready_evt(ready_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .iack(iack),
        .irq_drive_low(irq_drive_low), .data_oe(data_oe), .data_out(data_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_ready();
        ready_evt = 1'b1;
        step();
        ready_evt = 1'b0;
    endtask

    function automatic logic [31:0] frame(input logic [7:0] c, input logic [15:0] i);
        return {8'h00, i, c};
    endfunction

    // Full acknowledge cycle with expected frame queued for the monitor.
    task automatic do_ack(input logic [31:0] exp);
        expq.push_back(exp);
        iack = 1'b1;
        step();
        check(data_oe == 1'b1, "R8 accept", {31'd0, data_oe}, 32'd1);
        check(irq_drive_low == 1'b0, "R6 line released", {31'd0, irq_drive_low}, 32'd0);
        iack = 1'b0;
        step();
        check(data_oe == 1'b0, "R10 reply ends", {31'd0, data_oe}, 32'd0);
        check(data_out == 32'd0, "R5 idle zero", data_out, 32'd0);
    endtask

    // Monitor: compare each reply frame against the scoreboard.
    always @(negedge clk) begin
        if (data_oe && !prev_oe) begin
            if (expq.size() == 0) begin
                check(1'b0, "R8 unexpected reply", data_out, 32'd0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                check(data_out === e, "R4 frame", data_out, e);
            end
        end
        prev_oe <= data_oe;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(irq_drive_low == 1'b0, "R9 line", {31'd0, irq_drive_low}, 32'd0);
        check(data_oe == 1'b0, "R9 oe", {31'd0, data_oe}, 32'd0);
        check(data_out == 32'd0, "R5 data at reset", data_out, 32'd0);

        pulse_ready();
        check(irq_drive_low == 1'b0, "R3 disabled", {31'd0, irq_drive_low}, 32'd0);
        wr(2'd0, 16'h0001);
        check(irq_drive_low == 1'b1, "R3 enabled pending", {31'd0, irq_drive_low}, 32'd1);

        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h1234);
        // R4: rewrite code during the answer; frame must hold.
        expq.push_back(frame(8'hA5, 16'h1234));
        iack = 1'b1;
        step();
        check(data_oe == 1'b1, "R8 accept", {31'd0, data_oe}, 32'd1);
        check(irq_drive_low == 1'b0, "R6 cleared", {31'd0, irq_drive_low}, 32'd0);
        wr(2'd1, 16'h00FF);
        check(data_out == frame(8'hA5, 16'h1234), "R4 held", data_out, frame(8'hA5, 16'h1234));
        iack = 1'b0;
        step();
        check(data_oe == 1'b0, "R10 end", {31'd0, data_oe}, 32'd0);

        // R8: acknowledge with nothing pending, then request under held iack.
        iack = 1'b1;
        step();
        check(data_oe == 1'b0, "R8 no pending", {31'd0, data_oe}, 32'd0);
        pulse_ready();
        step();
        check(irq_drive_low == 1'b1, "R8 still requesting", {31'd0, irq_drive_low}, 32'd1);
        check(data_oe == 1'b0, "R8 held iack", {31'd0, data_oe}, 32'd0);
        iack = 1'b0;
        step();
        do_ack(frame(8'hFF, 16'h1234));

        // R1: spare address changes nothing.
        wr(2'd3, 16'hBEEF);
        pulse_ready();
        do_ack(frame(8'hFF, 16'h1234));

        // R7: software clear.
        pulse_ready();
        check(irq_drive_low == 1'b1, "R7 pending", {31'd0, irq_drive_low}, 32'd1);
        wr(2'd0, 16'h0003);
        check(irq_drive_low == 1'b0, "R7 cleared", {31'd0, irq_drive_low}, 32'd0);

        // R2: ready and clear in the same cycle.
        ready_evt = 1'b1;
        wr(2'd0, 16'h0003);
        ready_evt = 1'b0;
        check(irq_drive_low == 1'b1, "R2 set wins", {31'd0, irq_drive_low}, 32'd1);

        // R3: disable hides, re-enable restores.
        wr(2'd0, 16'h0000);
        check(irq_drive_low == 1'b0, "R3 hidden", {31'd0, irq_drive_low}, 32'd0);
        wr(2'd0, 16'h0001);
        check(irq_drive_low == 1'b1, "R3 kept", {31'd0, irq_drive_low}, 32'd1);
        wr(2'd2, 16'hC0DE);
        do_ack(frame(8'hFF, 16'hC0DE));

        // R2: ready during the accept cycle keeps a new request.
        pulse_ready();
        expq.push_back(frame(8'hFF, 16'hC0DE));
        ready_evt = 1'b1;
        iack = 1'b1;
        step();
        ready_evt = 1'b0;
        check(irq_drive_low == 1'b1, "R2 re-set on accept", {31'd0, irq_drive_low}, 32'd1);
        iack = 1'b0;
        step();
        do_ack(frame(8'hFF, 16'hC0DE));

        // R8: acknowledge while disabled is ignored.
        wr(2'd0, 16'h0000);
        pulse_ready();
        iack = 1'b1;
        step();
        check(data_oe == 1'b0, "R8 disabled", {31'd0, data_oe}, 32'd0);
        iack = 1'b0;
        step();

        check(expq.size() == 0, "R4 scoreboard drained", expq.size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule